// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block follows a chain of DMA control blocks in memory for a single channel. Each control block starts with a 64-bit word that points to the next block. A 64-bit info word comes next. After that, each data block has one status word and one data pointer. The number of data blocks per control block is a channel setting. The walker fetches these words one at a time over a 64-bit read port that allows one outstanding request. It hands each data block's pointer, status and info to a data mover, then writes the mover's returned status back to memory before it fetches anything else.

The walker raises two interrupt pulses. One marks a finished frame, meaning a written-back status with the end-of-frame flag set. The other marks an exhausted list, meaning a next pointer of zero. Alignment faults do not raise either pulse. A misaligned control-block address, or a bad data block on an extraction channel, sets a sticky error flag and stops the channel. Only reset clears that flag.

Memory layout relative to a control block base B:
- Next pointer at B.
- Info word at B+8.
- Status of block i at B+16+16i.
- Pointer of block i at B+24+16i.

Top module: `dcb_walker`

## Requirements
- R1: After reset, busy, irqFrame, irqList, errFlag, rdReq, wrReq and blkValid are all 0.
- R2: For each control block at base B, the walker reads B, then B+8, then for each data block i the status at B+16+16i followed by the pointer at B+24+16i. Every read address has bits [2:0] equal to zero.
- R3: Each data block is offered with blkValid together with its pointer (the full 64-bit word), its status (the low 32 bits of the status word) and the control block's info word. blkValid and these values hold steady until blkReady is seen.
- R4: When a block is accepted, the walker writes the word {upper 32 bits of the fetched status word, moverStatus with bit 31 set} to that block's status address. The write is acknowledged before any further read is issued.
- R5: cfgBlocks (1 to 15) sets the number of data blocks per control block and is sampled at start. A start with cfgBlocks equal to 0 sets errFlag and issues no read.
- R6: irqFrame pulses for one cycle, in the cycle after a write-back is acknowledged, when bit 17 (end of frame) of the written status is set.
- R7: A next pointer of all zeros ends the walk. irqList pulses for one cycle and busy drops in the same cycle.
- R8: A start address or next pointer with bits [2:0] not all zero sets errFlag and halts the walk without irqList. No further reads are issued and no further blocks are offered.
- R9: With cfgExtract set at start, a data block whose pointer bits [2:0] are not zero, or whose length field (status bits [15:0]) is not a multiple of 128, sets errFlag before the block is offered. With cfgExtract clear, neither condition is checked.
- R10: start is ignored while busy is 1 or errFlag is 1.
- R11: errFlag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at startAddr |
| startAddr | input | ADDR_W | Byte address of the first control block |
| cfgBlocks | input | 4 | Data blocks per control block |
| cfgExtract | input | 1 | Extraction channel: enable data block checks |
| rdReq | output | 1 | Read request, held until rdValid |
| rdAddr | output | ADDR_W | Read byte address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 64 | Read data |
| wrReq | output | 1 | Write request, held until wrAck |
| wrAddr | output | ADDR_W | Write byte address |
| wrData | output | 64 | Write data |
| wrAck | input | 1 | Write acknowledge |
| blkValid | output | 1 | Data block offered to the mover |
| blkReady | input | 1 | Mover accepts the block |
| blkPtr | output | 64 | Data block pointer word |
| blkStatus | output | 32 | Data block status |
| blkInfo | output | 64 | Control block info word |
| moverStatus | input | 32 | Status returned by the mover on accept |
| busy | output | 1 | Walk in progress |
| irqFrame | output | 1 | Frame-done pulse |
| irqList | output | 1 | List-exhausted pulse |
| errFlag | output | 1 | Sticky alignment error |

## Verification
The walk is exercised with the following lists:
- Single-block and multi-block control blocks.
- Two-block chains.
- The full fifteen-block count.

Together these separate the block-index address arithmetic from the chaining through next pointers.

Misaligned data pointers are applied on both an extraction and an injection channel. Comparing the two shows that the checks are gated by mode. A bad length and a misaligned next pointer locate where an error stops the walk: the read count, the number of accepted blocks and the interrupt counts must all match the point of failure.

Read and write event logs confirm that the fetch order holds and that each write-back comes before the next fetch. A start given mid-walk, a start after an error and a zero block count show which starts the walker ignores or rejects.

// File: rtl/dcb_walker_pkg.sv
package dcb_walker_pkg;
  typedef enum logic [1:0] {F_NEXT, F_INFO, F_STAT, F_PTR} fetch_e;

  typedef struct packed {
    logic loadBase;
    logic capWord;
    logic capMover;
    logic incIdx;
    logic advance;
    logic setErr;
  } dcbw_strobe_t;

  localparam int unsigned DONE_BIT  = 31;
  localparam int unsigned EOF_BIT   = 17;
  localparam int unsigned LEN_ALIGN = 7;
  localparam int unsigned WORD_ALIGN = 3;
  localparam int unsigned CNT_W     = 4;
endpackage

// File: rtl/dcb_walker_dpath.sv
module dcb_walker_dpath
  import dcb_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dcbw_strobe_t         strb,
  input  fetch_e               fetchKind,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [CNT_W-1:0]     cfgBlocks,
  input  logic                 cfgExtract,
  input  logic [63:0]          rdData,
  input  logic [31:0]          moverStatus,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [63:0]          wrData,
  output logic [63:0]          blkPtr,
  output logic [31:0]          blkStatus,
  output logic [63:0]          blkInfo,
  output logic                 errFlag,
  output logic                 startBad,
  output logic                 ptrBad,
  output logic                 lastBlk,
  output logic                 nextZero,
  output logic                 nextBad,
  output logic                 wbEof
);
  localparam int unsigned PAD_W = ADDR_W - CNT_W - 4;

  logic [ADDR_W-1:0] baseAddr;
  logic [63:0]       nextWord, infoWord, statWord, ptrWord;
  logic [CNT_W-1:0]  blkIdx, blkCnt;
  logic              extModeQ;
  logic [ADDR_W-1:0] pairOff, fetchOff;

  assign pairOff = {{PAD_W{1'b0}}, blkIdx, 4'b0000};

  always_comb begin
    case (fetchKind)
      F_NEXT:  fetchOff = '0;
      F_INFO:  fetchOff = ADDR_W'(8);
      F_STAT:  fetchOff = pairOff + ADDR_W'(16);
      default: fetchOff = pairOff + ADDR_W'(24);
    endcase
  end

  assign rdAddr    = baseAddr + fetchOff;
  assign wrAddr    = baseAddr + pairOff + ADDR_W'(16);
  assign wrData    = {statWord[63:32], statWord[31:0] | (32'd1 << DONE_BIT)};
  assign blkPtr    = ptrWord;
  assign blkStatus = statWord[31:0];
  assign blkInfo   = infoWord;

  assign startBad = (startAddr[WORD_ALIGN-1:0] != '0) || (cfgBlocks == '0);
  assign ptrBad   = extModeQ && ((ptrWord[WORD_ALIGN-1:0] != '0) ||
                                 (statWord[LEN_ALIGN-1:0] != '0));
  assign lastBlk  = (blkIdx == blkCnt - CNT_W'(1));
  assign nextZero = (nextWord == 64'd0);
  assign nextBad  = (nextWord[WORD_ALIGN-1:0] != '0);
  assign wbEof    = statWord[EOF_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      nextWord <= '0;
      infoWord <= '0;
      statWord <= '0;
      ptrWord  <= '0;
      blkIdx   <= '0;
      blkCnt   <= '0;
      extModeQ <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.loadBase) begin
        baseAddr <= startAddr;
        blkIdx   <= '0;
        blkCnt   <= cfgBlocks;
        extModeQ <= cfgExtract;
      end
      if (strb.advance) begin
        baseAddr <= nextWord[ADDR_W-1:0];
        blkIdx   <= '0;
      end
      if (strb.incIdx) blkIdx <= blkIdx + CNT_W'(1);
      if (strb.capWord) begin
        case (fetchKind)
          F_NEXT:  nextWord <= rdData;
          F_INFO:  infoWord <= rdData;
          F_STAT:  statWord <= rdData;
          default: ptrWord  <= rdData;
        endcase
      end
      if (strb.capMover) statWord[31:0] <= moverStatus;
      if (strb.setErr) errFlag <= 1'b1;
    end
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    baseAddr[WORD_ALIGN-1:0] == '0);

  assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.loadBase) |=> blkCnt != '0);
endmodule

// File: rtl/dcb_walker_ctrl.sv
module dcb_walker_ctrl
  import dcb_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         startBad,
  input  logic         errFlag,
  input  logic         ptrBad,
  input  logic         lastBlk,
  input  logic         nextZero,
  input  logic         nextBad,
  input  logic         wbEof,
  input  logic         rdValid,
  input  logic         wrAck,
  input  logic         blkReady,
  output dcbw_strobe_t strb,
  output fetch_e       fetchKind,
  output logic         rdReq,
  output logic         wrReq,
  output logic         blkValid,
  output logic         busy,
  output logic         irqFrame,
  output logic         irqList
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_MOVE, S_WB, S_NEXT} state_e;

  state_e state, nextState;
  fetch_e kindQ, kindNext;

  assign fetchKind = kindQ;
  assign busy      = (state != S_IDLE);

  always_comb begin
    nextState = state;
    kindNext  = kindQ;
    strb      = '0;
    rdReq     = 1'b0;
    wrReq     = 1'b0;
    blkValid  = 1'b0;
    case (state)
      S_IDLE: begin
        if (start && !errFlag) begin
          if (startBad) begin
            strb.setErr = 1'b1;
          end else begin
            strb.loadBase = 1'b1;
            kindNext      = F_NEXT;
            nextState     = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        rdReq = 1'b1;
        if (rdValid) begin
          strb.capWord = 1'b1;
          case (kindQ)
            F_NEXT:  kindNext = F_INFO;
            F_INFO:  kindNext = F_STAT;
            F_STAT:  kindNext = F_PTR;
            default: nextState = S_CHECK;
          endcase
        end
      end
      S_CHECK: begin
        if (ptrBad) begin
          strb.setErr = 1'b1;
          nextState   = S_IDLE;
        end else begin
          nextState = S_MOVE;
        end
      end
      S_MOVE: begin
        blkValid = 1'b1;
        if (blkReady) begin
          strb.capMover = 1'b1;
          nextState     = S_WB;
        end
      end
      S_WB: begin
        wrReq = 1'b1;
        if (wrAck) begin
          if (lastBlk) begin
            nextState = S_NEXT;
          end else begin
            strb.incIdx = 1'b1;
            kindNext    = F_STAT;
            nextState   = S_FETCH;
          end
        end
      end
      S_NEXT: begin
        if (nextZero) begin
          nextState = S_IDLE;
        end else if (nextBad) begin
          strb.setErr = 1'b1;
          nextState   = S_IDLE;
        end else begin
          strb.advance = 1'b1;
          kindNext     = F_NEXT;
          nextState    = S_FETCH;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kindQ    <= F_NEXT;
      irqFrame <= 1'b0;
      irqList  <= 1'b0;
    end else begin
      state    <= nextState;
      kindQ    <= kindNext;
      irqFrame <= (state == S_WB) && wrAck && wbEof;
      irqList  <= (state == S_NEXT) && nextZero;
    end
  end

  assert_no_rd_during_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && !rdReq);

  assert_halt_after_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);
endmodule

// File: rtl/dcb_walker.sv
module dcb_walker
  import dcb_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [3:0]        cfgBlocks,
  input  logic              cfgExtract,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [63:0]       rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [63:0]       wrData,
  input  logic              wrAck,
  output logic              blkValid,
  input  logic              blkReady,
  output logic [63:0]       blkPtr,
  output logic [31:0]       blkStatus,
  output logic [63:0]       blkInfo,
  input  logic [31:0]       moverStatus,
  output logic              busy,
  output logic              irqFrame,
  output logic              irqList,
  output logic              errFlag
);
  dcbw_strobe_t strb;
  fetch_e       fetchKind;
  logic startBad, ptrBad, lastBlk, nextZero, nextBad, wbEof;

  dcb_walker_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .startBad(startBad),
    .errFlag(errFlag), .ptrBad(ptrBad), .lastBlk(lastBlk),
    .nextZero(nextZero), .nextBad(nextBad), .wbEof(wbEof),
    .rdValid(rdValid), .wrAck(wrAck), .blkReady(blkReady),
    .strb(strb), .fetchKind(fetchKind), .rdReq(rdReq), .wrReq(wrReq),
    .blkValid(blkValid), .busy(busy), .irqFrame(irqFrame), .irqList(irqList)
  );

  dcb_walker_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchKind(fetchKind),
    .startAddr(startAddr), .cfgBlocks(cfgBlocks), .cfgExtract(cfgExtract),
    .rdData(rdData), .moverStatus(moverStatus),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData),
    .blkPtr(blkPtr), .blkStatus(blkStatus), .blkInfo(blkInfo),
    .errFlag(errFlag), .startBad(startBad), .ptrBad(ptrBad),
    .lastBlk(lastBlk), .nextZero(nextZero), .nextBad(nextBad), .wbEof(wbEof)
  );

  assert_rd_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[2:0] == 3'b000);

  assert_blk_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    blkValid && !blkReady |=> blkValid && $stable(blkPtr) && $stable(blkStatus)
                              && $stable(blkInfo));

  assert_wb_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && $stable(wrAddr) && $stable(wrData));

  assert_frame_irq_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqFrame |-> $past(wrReq && wrAck));

  assert_list_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqList |-> !busy && !errFlag);

  assert_quiet_on_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !rdReq && !blkValid);
endmodule

// File: tb/dcb_walker_tb_top.sv
module dcb_walker_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam logic [31:0] EOF_M  = 32'h0002_0000;
  localparam logic [31:0] MOVED  = 32'h0000_0100;
  localparam logic [31:0] DONE_M = 32'h8000_0000;

  // scenario table: blocks, extract, chain length, fault, expected results
  // fault: 0 none, 1 data pointer +4 at first cb block 1, 2 length 100 at same, 3 next pointer +4
  localparam int NV = 7;
  localparam int vBlk[NV]    = '{1, 3, 15, 2, 2, 2, 1};
  localparam int vExt[NV]    = '{0, 0, 1, 1, 1, 0, 0};
  localparam int vDcb[NV]    = '{1, 2, 1, 2, 2, 1, 2};
  localparam int vFault[NV]  = '{0, 0, 0, 1, 2, 1, 3};
  localparam int vMoves[NV]  = '{1, 6, 15, 1, 1, 2, 1};
  localparam int vFrames[NV] = '{1, 2, 1, 0, 0, 1, 1};
  localparam int vList[NV]   = '{1, 1, 1, 0, 0, 1, 0};
  localparam int vErr[NV]    = '{0, 0, 0, 1, 1, 0, 1};
  localparam int vReads[NV]  = '{4, 16, 32, 6, 6, 6, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [3:0] cfgBlocks = 4'd1;
  logic cfgExtract = 1'b0;
  logic rdReq, wrReq, blkValid, busy, irqFrame, irqList, errFlag;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic rdValid = 1'b0;
  logic [63:0] rdData = '0;
  logic [63:0] wrData, blkPtr, blkInfo;
  logic wrAck = 1'b0;
  logic blkReady = 1'b0;
  logic [31:0] blkStatus, moverStatus;

  assign moverStatus = blkStatus | MOVED;

  always #5 clk = ~clk;

  dcb_walker #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .cfgBlocks(cfgBlocks), .cfgExtract(cfgExtract),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck),
    .blkValid(blkValid), .blkReady(blkReady), .blkPtr(blkPtr),
    .blkStatus(blkStatus), .blkInfo(blkInfo), .moverStatus(moverStatus),
    .busy(busy), .irqFrame(irqFrame), .irqList(irqList), .errFlag(errFlag)
  );

  logic [63:0] mem [0:1023];
  int nChecks = 0, nFails = 0;
  int readCnt = 0, moveCnt = 0, frameCnt = 0, listCnt = 0, blkMis = 0;
  int evCnt = 0;
  logic [31:0] evAddr [0:63];
  logic        evWr   [0:63];
  int curBlk = 1, curFault = 0;
  int rdWait = 0;

  function automatic int idx(input logic [31:0] a);
    return int'((a >> 3) & 32'h3FF);
  endfunction

  function automatic logic [31:0] cbBase(input int d);
    return 32'h40 + 32'h200 * d;
  endfunction

  function automatic logic [63:0] expPtr(input int d, input int b, input int f);
    logic [63:0] p;
    p = 64'h1000 + 64'(d) * 64'h800 + 64'(b) * 64'h80;
    if (f == 1 && d == 0 && b == 1) p = p | 64'h4;
    return p;
  endfunction

  function automatic logic [31:0] expStat(input int d, input int b, input int nb, input int f);
    logic [31:0] s;
    s = 32'(128 * (b + 1));
    if (f == 2 && d == 0 && b == 1) s = 32'd100;
    if (b == nb - 1) s = s | EOF_M;
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic buildList(input int nb, input int nd, input int f);
    for (int i = 0; i < 1024; i++) mem[i] = 64'h0;
    for (int d = 0; d < nd; d++) begin
      logic [31:0] b0;
      logic [63:0] nx;
      b0 = cbBase(d);
      nx = (d == nd - 1) ? 64'h0 : 64'(cbBase(d + 1));
      if (f == 3 && d == 0) nx = nx | 64'h4;
      mem[idx(b0)]     = nx;
      mem[idx(b0 + 8)] = 64'hA000 + 64'(d);
      for (int b = 0; b < nb; b++) begin
        mem[idx(b0 + 32'(16 + 16 * b))] = {32'h0, expStat(d, b, nb, f)};
        mem[idx(b0 + 32'(24 + 16 * b))] = expPtr(d, b, f);
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readCnt = 0; moveCnt = 0; frameCnt = 0; listCnt = 0; blkMis = 0; evCnt = 0;
  endtask

  task automatic pulseStart(input logic [31:0] a);
    startAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // memory read responder: data two cycles after request
  initial forever begin
    @(posedge clk);
    if (rdValid) begin
      rdValid <= 1'b0;
    end else if (rstN && rdReq) begin
      if (rdWait == 1) begin
        rdValid <= 1'b1;
        rdData  <= mem[idx(rdAddr)];
        rdWait  = 0;
        readCnt++;
        if (evCnt < 64) begin evAddr[evCnt] = rdAddr; evWr[evCnt] = 1'b0; end
        evCnt++;
      end else rdWait++;
    end
  end

  // memory write responder
  initial forever begin
    @(posedge clk);
    if (wrAck) wrAck <= 1'b0;
    else if (rstN && wrReq) begin
      wrAck <= 1'b1;
      mem[idx(wrAddr)] = wrData;
      if (evCnt < 64) begin evAddr[evCnt] = wrAddr; evWr[evCnt] = 1'b1; end
      evCnt++;
    end
  end

  // data mover model: accept one cycle after offer, check offered values (R3)
  initial forever begin
    @(posedge clk);
    if (blkReady) blkReady <= 1'b0;
    else if (rstN && blkValid) begin
      int d, b;
      d = moveCnt / curBlk;
      b = moveCnt % curBlk;
      if (blkPtr !== expPtr(d, b, curFault)) blkMis++;
      if (blkInfo !== 64'hA000 + 64'(d)) blkMis++;
      if (blkStatus !== expStat(d, b, curBlk, curFault)) blkMis++;
      blkReady <= 1'b1;
      moveCnt++;
    end
  end

  // interrupt pulse counters
  initial forever begin
    @(negedge clk);
    if (irqFrame) frameCnt++;
    if (irqList) listCnt++;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 irqFrame", 64'(irqFrame), 64'd0);
    check("R1 irqList", 64'(irqList), 64'd0);
    check("R1 errFlag", 64'(errFlag), 64'd0);
    check("R1 rdReq/wrReq/blkValid", 64'({rdReq, wrReq, blkValid}), 64'd0);

    // table of scenarios
    for (int v = 0; v < NV; v++) begin
      logic [31:0] s0;
      doReset();
      curBlk = vBlk[v];
      curFault = vFault[v];
      buildList(vBlk[v], vDcb[v], vFault[v]);
      cfgBlocks = 4'(vBlk[v]);
      cfgExtract = vExt[v][0];
      pulseStart(cbBase(0));
      waitIdle();
      check($sformatf("R3/R5 moves v%0d", v), 64'(moveCnt), 64'(vMoves[v]));
      check($sformatf("R6 frames v%0d", v), 64'(frameCnt), 64'(vFrames[v]));
      check($sformatf("R7 list v%0d", v), 64'(listCnt), 64'(vList[v]));
      check($sformatf("R8/R9 err v%0d", v), 64'(errFlag), 64'(vErr[v]));
      check($sformatf("R2 reads v%0d", v), 64'(readCnt), 64'(vReads[v]));
      check($sformatf("R2 order v%0d", v),
            {evAddr[0][15:0], evAddr[1][15:0], evAddr[2][15:0], evAddr[3][15:0]},
            64'h0040_0048_0050_0058);
      check($sformatf("R4 wb before next fetch v%0d", v),
            64'({evWr[4], evAddr[4]}), {31'd0, 1'b1, 32'h50});
      s0 = expStat(0, 0, vBlk[v], vFault[v]);
      check($sformatf("R4 wb value v%0d", v), mem[idx(32'h50)], {32'h0, s0 | MOVED | DONE_M});
      check($sformatf("R3 offered values v%0d", v), 64'(blkMis), 64'd0);
    end

    // R8: misaligned start address
    doReset();
    buildList(1, 1, 0);
    curBlk = 1; curFault = 0;
    cfgBlocks = 4'd1; cfgExtract = 1'b0;
    pulseStart(32'h44);
    repeat (4) @(negedge clk);
    check("R8 start misaligned err", 64'(errFlag), 64'd1);
    check("R8 start misaligned no read", 64'(readCnt), 64'd0);
    // R10/R11: start ignored with error set, flag sticky
    pulseStart(32'h40);
    repeat (10) @(negedge clk);
    check("R10 start ignored on err", 64'(readCnt + moveCnt), 64'd0);
    check("R11 err stays", 64'(errFlag), 64'd1);

    // R5: zero block count
    doReset();
    cfgBlocks = 4'd0;
    pulseStart(32'h40);
    repeat (4) @(negedge clk);
    check("R5 zero count err", 64'(errFlag), 64'd1);
    check("R5 zero count no read", 64'(readCnt), 64'd0);

    // R10: start during a walk has no effect
    doReset();
    buildList(3, 2, 0);
    curBlk = 3; curFault = 0;
    cfgBlocks = 4'd3;
    pulseStart(32'h40);
    repeat (8) @(negedge clk);
    cfgBlocks = 4'd1;
    pulseStart(32'h240);
    waitIdle();
    check("R10 busy start reads", 64'(readCnt), 64'd16);
    check("R10 busy start moves", 64'(moveCnt), 64'd6);
    check("R10 busy start list", 64'(listCnt), 64'd1);

    // R9: extraction length fault on first block stops before any offer
    doReset();
    buildList(1, 1, 0);
    mem[idx(32'h50)] = {32'h0, 32'd200 | EOF_M};
    cfgBlocks = 4'd1; cfgExtract = 1'b1;
    pulseStart(32'h40);
    waitIdle();
    check("R9 first block bad length err", 64'(errFlag), 64'd1);
    check("R9 first block not offered", 64'(moveCnt), 64'd0);

    finishRun();
  end
endmodule